// File: doc/BRIEF.md
# Locking Input Capture Register

This block timestamps an external event. An 8-bit counter runs on the oscillator clock through a divide-by-32 prescaler. The capture pin is asynchronous, so it passes through a synchronizer. On a rising edge of the synchronized pin, the block copies the counter value into a capture register that software can only read, and it raises a pending flag.

While the flag is pending, the captured byte is locked: later edges are dropped, so software always sees the first event since its last read. A bus read of the capture register clears the flag and arms the block for the next event. No write path is involved.

A halt request freezes the prescaler and the counter. Edges that arrive during halt still capture, but they all return the frozen count. An interrupt request is raised while the flag is pending and the interrupt enable pin is high. The read path is a single-cycle strobe with an address select and no back-pressure. The block has no streaming data path, so every pin is a plain level or strobe and no valid/ready handshake applies.

Top module: `icap_latch`

## Requirements
- R1: After reset, `cap_data` is 00h, `cap_flag` is 0, `irq` is 0 and the internal count is 00h.
- R2: The counter increases by one for every 32 clock cycles that are not halted, and it wraps from FFh to 00h.
- R3: While `halt` is high, the prescaler and the counter hold their values, so every capture taken during halt returns the same count.
- R4: `cap_pin` is sampled by a two-flop synchronizer. The count present at the third rising clock edge after the pin goes high is loaded into `cap_data`, and it is visible after that edge.
- R5: `cap_flag` rises at the same edge that loads `cap_data`.
- R6: While `cap_flag` is 1, rising edges on `cap_pin` are ignored and `cap_data` keeps its value.
- R7: A read is a cycle with `rd_stb` = 1 and `rd_sel` = 1. It clears `cap_flag` at the next edge. A cycle with `rd_stb` = 1 and `rd_sel` = 0 has no effect.
- R8: When a read and a synchronized rising edge occur in the same cycle, the flag clears, the edge is discarded and `cap_data` is unchanged.
- R9: `irq` is 1 exactly when `cap_flag` = 1 and `irq_en` = 1. This is a combinational relation with no added delay.
- R10: A falling edge on `cap_pin` never starts a capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input; a rising edge triggers a capture |
| halt | input | 1 | Freezes the prescaler and the counter while high |
| rd_stb | input | 1 | Bus read strobe |
| rd_sel | input | 1 | Address select for the capture register |
| irq_en | input | 1 | Capture interrupt enable |
| cap_data | output | 8 | Count held at the last accepted capture |
| cap_flag | output | 1 | Capture pending; blocks further captures |
| irq | output | 1 | Interrupt request |

## Verification
A wrong internal state shows up at the ports in different ways:
- A prescaler or counter that is off by a count, or that keeps running during halt, is hidden until the next capture. It then appears as a `cap_data` value that differs from the reference count. This is why the bench forces captures before halt, during halt and after the counter has wrapped.
- A flag that is stuck or cleared when it should not be is seen on `cap_flag` and `irq` at the very next edge.
- A broken lock lets a second edge overwrite `cap_data`. This is visible three cycles after that edge on the pin.

The reference model runs next to the design and is compared with it on every clock. Any divergence is therefore reported within the cycle in which it becomes observable.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int unsigned DEF_CNT_W  = 8;
  localparam int unsigned DEF_PRESC  = 32;
  localparam int unsigned DEF_SYNC_N = 2;

  // Outcome of one cycle in the capture holder.
  typedef enum logic [1:0] {
    HOLD_IDLE  = 2'd0,
    HOLD_TAKE  = 2'd1,
    HOLD_CLEAR = 2'd2,
    HOLD_BLOCK = 2'd3
  } hold_act_e;
endpackage

// File: rtl/icap_prescaler.sv
module icap_prescaler #(
  parameter int unsigned PRESC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  output logic tick
);
  generate
    if (PRESC <= 1) begin : g_direct
      // No division: every non-halted cycle is a tick.
      assign tick = !halt;
    end else begin : g_div
      localparam int unsigned PW = $clog2(PRESC);
      localparam logic [PW-1:0] LAST = PW'(PRESC - 1);
      logic [PW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_q <= '0;
        end else if (!halt) begin
          if (div_q == LAST) div_q <= '0;
          else               div_q <= div_q + 1'b1;
        end
      end

      assign tick = !halt && (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/icap_counter.sv
module icap_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;  // natural wrap at all-ones
  end
endmodule

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [SYNC_N-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= pin;
  end

  generate
    for (genvar i = 1; i < SYNC_N; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[SYNC_N-1];
  end

  assign rise = chain_q[SYNC_N-1] && !prev_q;
endmodule

// File: rtl/icap_hold.sv
module icap_hold
  import icap_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_q,
  output logic             flag_q
);
  hold_act_e act;

  always_comb begin
    if (clr)                 act = HOLD_CLEAR;  // read wins over a same-cycle edge
    else if (rise && flag_q) act = HOLD_BLOCK;
    else if (rise)           act = HOLD_TAKE;
    else                     act = HOLD_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      unique case (act)
        HOLD_TAKE: begin
          cap_q  <= cnt;
          flag_q <= 1'b1;
        end
        HOLD_CLEAR: flag_q <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/icap_latch.sv
module icap_latch
  import icap_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned PRESC  = DEF_PRESC,
  parameter int unsigned SYNC_N = DEF_SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin,
  input  logic             halt,
  input  logic             rd_stb,
  input  logic             rd_sel,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cap_data,
  output logic             cap_flag,
  output logic             irq
);
  logic             cnt_tick;
  logic [CNT_W-1:0] cnt_val;
  logic             edge_seen;
  logic             rd_hit;

  assign rd_hit = rd_stb && rd_sel;

  icap_prescaler #(.PRESC(PRESC)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .halt  (halt),
    .tick  (cnt_tick)
  );

  icap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (cnt_tick),
    .cnt   (cnt_val)
  );

  icap_sync_edge #(.SYNC_N(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (cap_pin),
    .rise  (edge_seen)
  );

  icap_hold #(.CNT_W(CNT_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (edge_seen),
    .clr    (rd_hit),
    .cnt    (cnt_val),
    .cap_q  (cap_data),
    .flag_q (cap_flag)
  );

  assign irq = cap_flag && irq_en;
endmodule

// File: rtl/icap_latch_chk.sv
module icap_latch_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt,
  input logic             rd_stb,
  input logic             rd_sel,
  input logic             irq_en,
  input logic [CNT_W-1:0] cap_data,
  input logic             cap_flag,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_val,
  input logic             edge_seen
);
  // R2: the count only ever steps by one (with wrap)
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val != $past(cnt_val)) |-> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)));

  // R3: halt freezes the count
  a_r3_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (cnt_val == $past(cnt_val)));

  // R5: the flag only rises after a synchronized edge
  a_r5_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> $past(edge_seen));

  // R6: a pending flag without a read keeps the data and the flag
  a_r6_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !(rd_stb && rd_sel)) |=> ($stable(cap_data) && cap_flag));

  // R7: a selected read clears the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_sel) |=> !cap_flag);

  // R8: an edge colliding with a read is dropped
  a_r8_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_sel && edge_seen) |=> $stable(cap_data));

  // R9: interrupt needs a pending flag, and an enabled pending flag raises it
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cap_flag && irq_en));
  a_r9_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && irq_en) |-> irq);
endmodule

bind icap_latch icap_latch_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/icap_latch_tb_top.sv
module icap_latch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_pin = 1'b0, halt = 1'b0, rd_stb = 1'b0, rd_sel = 1'b0, irq_en = 1'b0;
  logic [7:0] cap_data;
  logic       cap_flag, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Behavioural reference state
  int m_pin_hist[$];   // synchronized pin history, newest first
  int m_div = 0, m_cnt = 0, m_cap = 0, m_flag = 0;

  always #10 clk = ~clk;  // 50 MHz

  icap_latch dut_i (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .halt(halt),
    .rd_stb(rd_stb), .rd_sel(rd_sel), .irq_en(irq_en),
    .cap_data(cap_data), .cap_flag(cap_flag), .irq(irq)
  );

  initial begin
    m_pin_hist = '{0, 0, 0};
  end

  // Reference model: advanced on each rising edge from the inputs held there
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pin_hist = '{0, 0, 0};
      m_div = 0; m_cnt = 0; m_cap = 0; m_flag = 0;
    end else begin
      bit rise_now;
      rise_now = (m_pin_hist[1] == 1) && (m_pin_hist[2] == 0);
      if (rd_stb && rd_sel) m_flag = 0;
      else if (rise_now && m_flag == 0) begin
        m_cap = m_cnt; m_flag = 1;
      end
      m_pin_hist.push_front(int'(cap_pin));
      void'(m_pin_hist.pop_back());
      if (!halt) begin
        if (m_div == 31) begin
          m_div = 0; m_cnt = (m_cnt + 1) % 256;
        end else m_div++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Every-clock comparison, away from both edges
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R4 cap_data", int'(cap_data), m_cap);
      check("R5 cap_flag", int'(cap_flag), m_flag);
      check("R9 irq", int'(irq), (m_flag != 0 && irq_en) ? 1 : 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_rise();
    cap_pin = 1'b1; cyc(4);
  endtask

  task automatic pin_fall();
    cap_pin = 1'b0; cyc(4);
  endtask

  task automatic bus_read();
    rd_stb = 1'b1; rd_sel = 1'b1; cyc(1);
    rd_stb = 1'b0; rd_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int v1, v2, c0;
    cyc(3);
    // R1: reset state
    check("R1 cap_data", int'(cap_data), 0);
    check("R1 cap_flag", int'(cap_flag), 0);
    check("R1 irq", int'(irq), 0);
    rst_n = 1'b1;

    // R4/R5/R2: capture after the count has advanced
    cyc(100);
    pin_rise();
    #3;
    check("R5 flag set", int'(cap_flag), 1);
    check("R2 count at capture", int'(cap_data), m_cap);
    check("R2 count nonzero after 100 cycles", (cap_data >= 8'd3) ? 1 : 0, 1);

    // R9: enable toggles irq
    irq_en = 1'b1; #1;
    check("R9 irq with enable", int'(irq), 1);
    cyc(1);
    irq_en = 1'b0; #1;
    check("R9 irq without enable", int'(irq), 0);

    // R10: falling edge does nothing; R6: later edge while pending ignored
    c0 = int'(cap_data);
    pin_fall();
    cyc(70);
    pin_rise();
    #3;
    check("R6 data held while pending", int'(cap_data), c0);

    // R7: strobe without select is ignored; selected read clears
    rd_stb = 1'b1; cyc(1); rd_stb = 1'b0; #3;
    check("R7 unselected strobe ignored", int'(cap_flag), 1);
    bus_read(); #3;
    check("R7 read clears flag", int'(cap_flag), 0);

    // R10: a falling edge after the read captures nothing
    pin_fall(); #3;
    check("R10 fall no capture", int'(cap_flag), 0);
    check("R10 fall keeps data", int'(cap_data), c0);

    // R3: two captures during halt return the frozen count
    halt = 1'b1;
    pin_rise(); #3;
    v1 = int'(cap_data);
    check("R3 capture in halt", int'(cap_flag), 1);
    bus_read(); pin_fall(); cyc(100);
    pin_rise(); #3;
    v2 = int'(cap_data);
    check("R3 frozen count", v2, v1);
    halt = 1'b0;
    bus_read(); pin_fall();

    // R8: read collides with the synchronized edge
    pin_rise();
    c0 = int'(cap_data);
    pin_fall();
    cyc(40);
    cap_pin = 1'b1; cyc(2);
    rd_stb = 1'b1; rd_sel = 1'b1; cyc(1);
    rd_stb = 1'b0; rd_sel = 1'b0; #3;
    check("R8 flag cleared on collision", int'(cap_flag), 0);
    check("R8 data unchanged on collision", int'(cap_data), c0);
    cyc(3); #3;
    check("R8 edge discarded", int'(cap_flag), 0);
    pin_fall();

    // R2: run past a full wrap of the counter, then capture
    cyc(9000);
    pin_rise(); #3;
    check("R2 after wrap", int'(cap_data), m_cap);
    bus_read();
    cyc(5);
    finish_run();
  end
endmodule